// File: doc/BRIEF.md
# Stop-Point Column Address Remapper

This block sits beside a multiport video memory controller. It tracks whether the memory has been placed in stop-point mode and rewrites the column address of each memory cycle to match. The controller tells the block the type of each cycle through a valid strobe and a 3-bit cycle code.

One kind of refresh cycle, the option-set refresh, turns stop-point mode on. A plain option-clear refresh turns it off. While the mode is on, the two top column bits trade places. This lets one controller drive parts with either 256-bit or 512-bit serial registers.

While the mode is on, the block also reports which half of the DRAM row a split register transfer selects. It raises a warning when an option-clear refresh is requested while the mode is active, because that combination is discouraged.

The physical column address is combinational from the logical address and the current mode flag. It is therefore ready in the same cycle that the column strobe is requested.

Cycle codes on `cyc_type_i`, valid only when `cyc_vld_i` is 1:

| Code | Cycle |
|------|-------|
| 0 | idle |
| 1 | normal read/write |
| 2 | full register transfer |
| 3 | split register transfer |
| 4 | option-set refresh |
| 5 | option-clear refresh |
| 6, 7 | reserved, no effect |

Top module: `stpt_col_remap`

## Requirements
- R1: While `rst_ni` is low, `stop_mode_o` is 0, `col_o` equals `col_i`, and `half_vld_o`, `half_sel_o` and `warn_o` are 0.
- R2: A clock edge with `cyc_vld_i`=1 and `cyc_type_i`=4 sets `stop_mode_o` to 1 from the next cycle on.
- R3: A clock edge with `cyc_vld_i`=1 and `cyc_type_i`=5 clears `stop_mode_o` to 0 from the next cycle on.
- R4: Starting from reset, a run made only of option-clear refresh cycles (code 5) keeps `stop_mode_o` at 0 and `warn_o` at 0 throughout.
- R5: While `stop_mode_o`=1, `col_o[8]` equals `col_i[7]`, `col_o[7]` equals `col_i[8]`, and `col_o[6:0]` equals `col_i[6:0]`.
- R6: While `stop_mode_o`=0, `col_o` equals `col_i`.
- R7: The remap of R5 and R6 applies in the same cycle for every cycle code (0 to 7) and for `cyc_vld_i` at 0 or 1.
- R8: With `stop_mode_o`=1, `cyc_vld_i`=1 and code 3, `half_vld_o` is 1 and `half_sel_o` equals `col_i[7]`, whatever the value of `col_i[8]`.
- R9: `half_vld_o` and `half_sel_o` are 0 in every cycle that is not a valid split transfer (code 3) made while `stop_mode_o`=1.
- R10: `warn_o` is 1 exactly in the cycles where `cyc_vld_i`=1, code 5 is presented and `stop_mode_o`=1.
- R11: Codes 0, 1, 2, 3, 6 and 7, and any cycle with `cyc_vld_i`=0, leave `stop_mode_o` unchanged at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cyc_vld_i | input | 1 | A cycle code is presented this cycle |
| cyc_type_i | input | 3 | Cycle code, as listed in the table above |
| col_i | input | 9 | Logical column address |
| col_o | output | 9 | Physical column address |
| stop_mode_o | output | 1 | Stop-point mode flag |
| half_vld_o | output | 1 | `half_sel_o` is meaningful this cycle |
| half_sel_o | output | 1 | Row half selected by the split transfer |
| warn_o | output | 1 | Option-clear requested while stop-point mode is active |

## Verification
The hardest case to reach from the ports is the warning: it needs an option-clear refresh issued exactly while the mode flag is set.

A second hard case is a set followed at once by a clear. Here the warning fires on the first cycle after the set, and the flag drops one cycle later.

The directed stimulus places these sequences back to back. It also repeats the set and the clear to show that both are idempotent.

A pseudo-random phase then mixes all eight codes with toggling valid strobes and column values that set bits 7 and 8 to differing values. A reference model compares every output on every cycle.

// File: rtl/stpt_pkg.sv
package stpt_pkg;
  localparam int unsigned COL_W   = 9;
  localparam int unsigned SWAP_LO = 7;
  localparam int unsigned SWAP_HI = 8;
  localparam int unsigned CYC_W   = 3;

  typedef enum logic [CYC_W-1:0] {
    CYC_IDLE       = 3'd0,
    CYC_RW         = 3'd1,
    CYC_FULL_XFER  = 3'd2,
    CYC_SPLIT_XFER = 3'd3,
    CYC_MODE_SET   = 3'd4,
    CYC_MODE_CLR   = 3'd5
  } cyc_e;
endpackage

// File: rtl/stpt_cyc_decode.sv
module stpt_cyc_decode
  import stpt_pkg::*;
(
  input  logic             vld_i,
  input  logic [CYC_W-1:0] type_i,
  output logic             set_o,
  output logic             clr_o,
  output logic             split_o
);
  always_comb begin
    set_o   = 1'b0;
    clr_o   = 1'b0;
    split_o = 1'b0;
    if (vld_i) begin
      unique case (type_i)
        CYC_MODE_SET:   set_o   = 1'b1;
        CYC_MODE_CLR:   clr_o   = 1'b1;
        CYC_SPLIT_XFER: split_o = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stpt_mode_latch.sv
module stpt_mode_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic mode_o,
  output logic warn_o
);
  logic mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= 1'b0;
    else if (set_i) mode_q <= 1'b1;
    else if (clr_i) mode_q <= 1'b0;
  end

  assign mode_o = mode_q;
  // discouraged: clear while stop point active
  assign warn_o = clr_i & mode_q;
endmodule

// File: rtl/stpt_col_swap.sv
module stpt_col_swap #(
  parameter int unsigned COL_W   = 9,
  parameter int unsigned SWAP_LO = 7,
  parameter int unsigned SWAP_HI = 8
) (
  input  logic             swap_i,
  input  logic [COL_W-1:0] col_i,
  output logic [COL_W-1:0] col_o
);
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    if (b == SWAP_LO) begin : g_lo
      assign col_o[b] = swap_i ? col_i[SWAP_HI] : col_i[b];
    end else if (b == SWAP_HI) begin : g_hi
      assign col_o[b] = swap_i ? col_i[SWAP_LO] : col_i[b];
    end else begin : g_pass
      assign col_o[b] = col_i[b];
    end
  end
endmodule

// File: rtl/stpt_col_remap.sv
module stpt_col_remap
  import stpt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_vld_i,
  input  logic [CYC_W-1:0] cyc_type_i,
  input  logic [COL_W-1:0] col_i,
  output logic [COL_W-1:0] col_o,
  output logic             stop_mode_o,
  output logic             half_vld_o,
  output logic             half_sel_o,
  output logic             warn_o
);
  logic set_s, clr_s, split_s, mode_s;

  stpt_cyc_decode u_dec (
    .vld_i   (cyc_vld_i),
    .type_i  (cyc_type_i),
    .set_o   (set_s),
    .clr_o   (clr_s),
    .split_o (split_s)
  );

  stpt_mode_latch u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_s),
    .clr_i  (clr_s),
    .mode_o (mode_s),
    .warn_o (warn_o)
  );

  stpt_col_swap #(
    .COL_W   (COL_W),
    .SWAP_LO (SWAP_LO),
    .SWAP_HI (SWAP_HI)
  ) u_swap (
    .swap_i (mode_s),
    .col_i  (col_i),
    .col_o  (col_o)
  );

  assign stop_mode_o = mode_s;
  assign half_vld_o  = split_s & mode_s;
  // upper bit is don't-care; logical low swap bit picks the half
  assign half_sel_o  = half_vld_o & col_i[SWAP_LO];
endmodule

// File: rtl/stpt_col_remap_chk.sv
module stpt_col_remap_chk
  import stpt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cyc_vld_i,
  input logic [CYC_W-1:0] cyc_type_i,
  input logic [COL_W-1:0] col_i,
  input logic [COL_W-1:0] col_o,
  input logic             stop_mode_o,
  input logic             half_vld_o,
  input logic             half_sel_o,
  input logic             warn_o
);
  logic is_set, is_clr, is_split;
  assign is_set   = cyc_vld_i && cyc_type_i == CYC_MODE_SET;
  assign is_clr   = cyc_vld_i && cyc_type_i == CYC_MODE_CLR;
  assign is_split = cyc_vld_i && cyc_type_i == CYC_SPLIT_XFER;

  always_comb begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!stop_mode_o && col_o == col_i && !half_vld_o && !warn_o);
    end
  end

  p_set_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_set |=> stop_mode_o);

  p_clr_mode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_clr |=> !stop_mode_o);

  p_swap_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_mode_o |-> col_o[SWAP_HI] == col_i[SWAP_LO] && col_o[SWAP_LO] == col_i[SWAP_HI]);

  p_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_mode_o |-> col_o == col_i);

  p_half_sel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_split && stop_mode_o) |-> half_vld_o && half_sel_o == col_i[SWAP_LO]);

  p_half_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(is_split && stop_mode_o) |-> !half_vld_o && !half_sel_o);

  p_warn_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |-> stop_mode_o && is_clr);

  p_warn_needed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_mode_o && is_clr) |-> warn_o);

  p_mode_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_set && !is_clr) |=> $stable(stop_mode_o));
endmodule

bind stpt_col_remap stpt_col_remap_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cyc_vld_i   (cyc_vld_i),
  .cyc_type_i  (cyc_type_i),
  .col_i       (col_i),
  .col_o       (col_o),
  .stop_mode_o (stop_mode_o),
  .half_vld_o  (half_vld_o),
  .half_sel_o  (half_sel_o),
  .warn_o      (warn_o)
);

// File: tb/stpt_col_remap_tb.sv
module stpt_col_remap_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cyc_vld_i = 1'b0;
  logic [2:0] cyc_type_i = 3'd0;
  logic [8:0] col_i = 9'd0;
  logic [8:0] col_o;
  logic       stop_mode_o, half_vld_o, half_sel_o, warn_o;

  int n_run = 0;
  int n_fail = 0;
  int ref_mode = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  stpt_col_remap dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cyc_vld_i   (cyc_vld_i),
    .cyc_type_i  (cyc_type_i),
    .col_i       (col_i),
    .col_o       (col_o),
    .stop_mode_o (stop_mode_o),
    .half_vld_o  (half_vld_o),
    .half_sel_o  (half_sel_o),
    .warn_o      (warn_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, compare settled outputs, advance model at posedge
  task automatic step(input bit vld, input int typ, input int col, input string tag);
    int exp_col, exp_hv, exp_hs, exp_w;
    @(negedge clk_i);
    cyc_vld_i  = vld;
    cyc_type_i = typ[2:0];
    col_i      = col[8:0];
    #1;
    exp_col = col;
    if (ref_mode == 1) begin
      exp_col[8] = col[7];
      exp_col[7] = col[8];
    end
    exp_hv = (vld && typ == 3 && ref_mode == 1) ? 1 : 0;
    exp_hs = exp_hv ? col[7] : 0;
    exp_w  = (vld && typ == 5 && ref_mode == 1) ? 1 : 0;
    chk({tag, " mode R2/R3/R11"}, stop_mode_o, ref_mode);
    chk({tag, " col R5/R6/R7"}, col_o, exp_col);
    chk({tag, " half_vld R8/R9"}, half_vld_o, exp_hv);
    chk({tag, " half_sel R8/R9"}, half_sel_o, exp_hs);
    chk({tag, " warn R10"}, warn_o, exp_w);
    if (vld && typ == 4) ref_mode = 1;
    else if (vld && typ == 5) ref_mode = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lfsr;
    // R1: reset state
    col_i = 9'h180;
    #(CLK_PERIOD*2 + 1);
    chk("R1 mode", stop_mode_o, 0);
    chk("R1 col", col_o, 9'h180);
    chk("R1 half_vld", half_vld_o, 0);
    chk("R1 warn", warn_o, 0);
    rst_ni = 1'b1;

    // R4: only clears keep normal mode, no warning
    for (int i = 0; i < 4; i++) step(1, 5, 9'h080 + i, "R4 clr-only");
    step(1, 3, 9'h180, "R9 split in normal");
    step(1, 1, 9'h100, "R6 rw normal");
    // R11: ignored set with vld low and reserved codes
    step(0, 4, 9'h080, "R11 set no vld");
    step(1, 6, 9'h080, "R11 reserved 6");
    step(1, 7, 9'h080, "R11 reserved 7");
    // R2: set, idempotent
    step(1, 4, 9'h080, "R2 set");
    step(1, 4, 9'h100, "R2 set again");
    // R5/R7 across cycle codes
    for (int t = 0; t < 8; t++) if (t != 4 && t != 5) step(1, t, 9'h0A5, "R7 code sweep");
    step(0, 0, 9'h13C, "R5 no vld");
    // R8: half select, bit 8 don't-care
    step(1, 3, 9'h080, "R8 half1 b8=0");
    step(1, 3, 9'h180, "R8 half1 b8=1");
    step(1, 3, 9'h100, "R8 half0 b8=1");
    step(1, 3, 9'h000, "R8 half0 b8=0");
    // R10/R3: clear while active, then again
    step(1, 5, 9'h100, "R10 warn clr");
    step(1, 5, 9'h100, "R3 clr again");
    step(1, 2, 9'h180, "R6 full after clr");
    // set then immediate clear
    step(1, 4, 9'h000, "R2 set b2b");
    step(1, 5, 9'h080, "R10 clr b2b");
    step(1, 1, 9'h080, "R3 after b2b");

    // mixed pseudo-random traffic
    lfsr = 32'h1ACE5;
    for (int i = 0; i < 400; i++) begin
      lfsr = (lfsr << 1) ^ ((lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]) ? 1 : 0);
      step(lfsr[20] | lfsr[3], lfsr[10:8], lfsr[18:10], "R7 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule